// File: doc/BRIEF.md
# Byte-Masked Memory with Write Forwarding

This block is a single-clock memory with a write port and a read port that work side by side. A write carries an address, a data word and one enable bit for each byte lane. Only the enabled lanes of the addressed word are changed. The disabled lanes keep what they held before. A read returns the newest contents of its address after a fixed number of cycles. A read-valid strobe marks the returned word and can be set to arrive a configurable number of cycles before the data.

Each accepted write is first held in a one-entry pending slot. It is committed to the array on the following edge. If a read arrives on the edge right after a write to the same address, the pending write has not yet been committed. The read word is then built lane by lane: enabled lanes come from the pending write data, and the other lanes come from the array. In this way a read always sees every write accepted on an earlier edge.

Parameters are the data width (a multiple of 8), the address width, the read latency, the valid lead, and an option that clears the array on reset. When that option is off, the array starts with unknown contents.

Top module: `lane_mask_ram`

## Requirements
- R1: While `rst` is high and on the first cycle after it falls, `rd_valid` is 0. With `INIT_ZERO`=1, every address read after reset returns 0.
- R2: A write with `wr_be` all ones stores the whole `wr_data` word at `wr_addr`. A later read of that address returns it.
- R3: Bit i of `wr_be` (active high) enables data bits [8i+7:8i]. A lane whose bit is 0 keeps its previous value.
- R4: A read accepted on the edge right after a write to the same address returns the merged word. Lanes enabled in that write hold its new bytes, and all other lanes hold the array contents.
- R5: A read and a write to different addresses may be accepted on the same edge. The read returns the contents of its own address, unaffected by that write.
- R6: A read and a write to the same address accepted on the same edge: the read returns the word as it was before that write.
- R7: For a read accepted at edge e, `rd_data` holds its result from edge e+`RD_LAT`-1 up to edge e+`RD_LAT`. Reads on consecutive edges each produce their own word on consecutive cycles.
- R8: `rd_valid` is high for exactly the one cycle starting at edge e+`RD_LAT`-1-`VLD_LEAD` for each read accepted at edge e, and is low in every other cycle.
- R9: Two consecutive writes to one address followed at once by a read: the read shows the lanes of both writes, with the later write winning where both enable a lane.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write request accepted at the rising edge |
| wr_addr | input | ADDR_W | Write word address |
| wr_data | input | DATA_W | Write data |
| wr_be | input | DATA_W/8 | Per-lane write enables, bit i drives bits [8i+7:8i] |
| rd_en | input | 1 | Read request accepted at the rising edge |
| rd_addr | input | ADDR_W | Read word address |
| rd_data | output | DATA_W | Read result, meaningful in the cycle given by R7 |
| rd_valid | output | 1 | Read-valid strobe, leading the data by VLD_LEAD cycles |

## Verification
Two things can happen in the same cycle: committing the pending write to the array, and a read of that same word that must be served from the pending slot. The bench provokes this with a write followed at once by a read of the same address, for all sixteen lane masks. It also issues chained writes to one address and same-edge read/write pairs. Each returned word is judged against a bench-side array that applies the byte-mask rule at the edge where each write is accepted.

// File: rtl/lmr_pkg.sv
package lmr_pkg;

    localparam int BYTE_W = 8;

    // Number of byte lanes in a word of the given width
    function automatic int lane_count(input int data_w);
        return data_w / BYTE_W;
    endfunction

    // Replicate one lane-enable bit across a byte
    function automatic logic [BYTE_W-1:0] lane_fill(input logic en);
        return {BYTE_W{en}};
    endfunction

    // Per-lane source for a forwarded read
    typedef enum logic {
        SRC_ARRAY   = 1'b0,
        SRC_PENDING = 1'b1
    } lane_src_e;

endpackage

// File: rtl/lmr_wr_stage.sv
module lmr_wr_stage #(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 6,
    localparam int LANES = lmr_pkg::lane_count(DATA_W)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [LANES-1:0]  wr_be,
    output logic              q_vld,
    output logic [ADDR_W-1:0] q_addr,
    output logic [DATA_W-1:0] q_data,
    output logic [LANES-1:0]  q_be
);

    // One-entry pending slot: holds the write accepted on the last edge
    always_ff @(posedge clk) begin
        if (rst) begin
            q_vld <= 1'b0;
        end else begin
            q_vld <= wr_en;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            q_addr <= wr_addr;
            q_data <= wr_data;
            q_be   <= wr_be;
        end
    end

endmodule

// File: rtl/lmr_array.sv
module lmr_array #(
    parameter int DATA_W    = 32,
    parameter int ADDR_W    = 6,
    parameter bit INIT_ZERO = 1'b1,
    localparam int LANES    = lmr_pkg::lane_count(DATA_W),
    localparam int DEPTH    = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [LANES-1:0]  wbe,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);

    localparam int BW = lmr_pkg::BYTE_W;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [BW-1:0] lane_mem [DEPTH];

        if (INIT_ZERO) begin : g_clr
            always_ff @(posedge clk) begin
                if (rst) begin
                    for (int i = 0; i < DEPTH; i++) begin
                        lane_mem[i] <= '0;
                    end
                end else if (we && wbe[g]) begin
                    lane_mem[waddr] <= wdata[g*BW +: BW];
                end
            end
        end else begin : g_noclr
            always_ff @(posedge clk) begin
                if (we && wbe[g]) begin
                    lane_mem[waddr] <= wdata[g*BW +: BW];
                end
            end
        end

        assign rdata[g*BW +: BW] = lane_mem[raddr];
    end

endmodule

// File: rtl/lmr_fwd_merge.sv
module lmr_fwd_merge #(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 6,
    localparam int LANES = lmr_pkg::lane_count(DATA_W)
) (
    input  logic              p_vld,
    input  logic [ADDR_W-1:0] p_addr,
    input  logic [DATA_W-1:0] p_data,
    input  logic [LANES-1:0]  p_be,
    input  logic [ADDR_W-1:0] raddr,
    input  logic [DATA_W-1:0] arr_word,
    output logic [DATA_W-1:0] merged
);

    import lmr_pkg::*;

    localparam int BW = BYTE_W;

    logic hit;
    assign hit = p_vld && (p_addr == raddr);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        lane_src_e src;
        assign src = (hit && p_be[g]) ? SRC_PENDING : SRC_ARRAY;
        assign merged[g*BW +: BW] = (src == SRC_PENDING) ? p_data[g*BW +: BW]
                                                         : arr_word[g*BW +: BW];
    end

endmodule

// File: rtl/lmr_rd_pipe.sv
module lmr_rd_pipe #(
    parameter int DATA_W   = 32,
    parameter int RD_LAT   = 2,
    parameter int VLD_LEAD = 1,
    localparam int VL      = RD_LAT - VLD_LEAD
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              issue,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout,
    output logic              vld
);

    // Data stages shift every cycle; only the marked cycle is meaningful
    logic [DATA_W-1:0] dstg [RD_LAT];

    always_ff @(posedge clk) begin
        dstg[0] <= din;
        for (int k = RD_LAT - 1; k > 0; k--) begin
            dstg[k] <= dstg[k-1];
        end
    end

    assign dout = dstg[RD_LAT-1];

    // Valid chain is shorter than the data chain by the lead
    if (VL == 1) begin : g_v1
        logic vq;
        always_ff @(posedge clk) begin
            if (rst) vq <= 1'b0;
            else     vq <= issue;
        end
        assign vld = vq;
    end else begin : g_vn
        logic [VL-1:0] vsh;
        always_ff @(posedge clk) begin
            if (rst) vsh <= '0;
            else     vsh <= {vsh[VL-2:0], issue};
        end
        assign vld = vsh[VL-1];
    end

endmodule

// File: rtl/lane_mask_ram.sv
module lane_mask_ram #(
    parameter int DATA_W    = 32,
    parameter int ADDR_W    = 6,
    parameter int RD_LAT    = 2,
    parameter int VLD_LEAD  = 1,
    parameter bit INIT_ZERO = 1'b1,
    localparam int LANES    = lmr_pkg::lane_count(DATA_W)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [LANES-1:0]  wr_be,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid
);

    typedef struct packed {
        logic              vld;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
        logic [LANES-1:0]  be;
    } wr_slot_t;

    wr_slot_t          pend;
    logic [DATA_W-1:0] arr_rdata;
    logic [DATA_W-1:0] rd_merged;

    lmr_wr_stage #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_wst (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .wr_be   (wr_be),
        .q_vld   (pend.vld),
        .q_addr  (pend.addr),
        .q_data  (pend.data),
        .q_be    (pend.be)
    );

    lmr_array #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .INIT_ZERO(INIT_ZERO)) u_arr (
        .clk   (clk),
        .rst   (rst),
        .we    (pend.vld),
        .waddr (pend.addr),
        .wdata (pend.data),
        .wbe   (pend.be),
        .raddr (rd_addr),
        .rdata (arr_rdata)
    );

    lmr_fwd_merge #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_fwd (
        .p_vld    (pend.vld),
        .p_addr   (pend.addr),
        .p_data   (pend.data),
        .p_be     (pend.be),
        .raddr    (rd_addr),
        .arr_word (arr_rdata),
        .merged   (rd_merged)
    );

    lmr_rd_pipe #(.DATA_W(DATA_W), .RD_LAT(RD_LAT), .VLD_LEAD(VLD_LEAD)) u_pipe (
        .clk   (clk),
        .rst   (rst),
        .issue (rd_en),
        .din   (rd_merged),
        .dout  (rd_data),
        .vld   (rd_valid)
    );

endmodule

// File: rtl/lmr_chk.sv
module lmr_chk #(
    parameter int DATA_W   = 32,
    parameter int ADDR_W   = 6,
    parameter int RD_LAT   = 2,
    parameter int VLD_LEAD = 1,
    localparam int LANES   = lmr_pkg::lane_count(DATA_W),
    localparam int VL      = RD_LAT - VLD_LEAD
) (
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [DATA_W-1:0] wr_data,
    input logic [LANES-1:0]  wr_be,
    input logic              rd_en,
    input logic [ADDR_W-1:0] rd_addr,
    input logic              rd_valid,
    input logic              p_vld,
    input logic [DATA_W-1:0] merged,
    input logic [DATA_W-1:0] arr_word
);

    localparam int BW = lmr_pkg::BYTE_W;

    // Independent record of the previous edge's write, taken at the ports
    logic              last_we;
    logic [ADDR_W-1:0] last_addr;
    logic [DATA_W-1:0] last_data;
    logic [DATA_W-1:0] last_mask;
    logic [DATA_W-1:0] in_mask;
    logic [VL-1:0]     vsh;

    for (genvar g = 0; g < LANES; g++) begin : g_m
        assign in_mask[g*BW +: BW] = lmr_pkg::lane_fill(wr_be[g]);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            last_we <= 1'b0;
            vsh     <= '0;
        end else begin
            last_we <= wr_en;
            vsh     <= (VL == 1) ? VL'(rd_en) : VL'({vsh, rd_en});
        end
        last_addr <= wr_addr;
        last_data <= wr_data;
        last_mask <= in_mask;
    end

    logic fwd_case;
    assign fwd_case = rd_en && last_we && (rd_addr == last_addr);

    p_valid_clear_after_reset_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !rd_valid);

    p_pend_clear_after_reset_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !p_vld);

    p_fwd_new_lanes_r4: assert property (@(posedge clk) disable iff (rst)
        fwd_case |-> (((merged ^ last_data) & last_mask) == '0));

    p_fwd_old_lanes_r4: assert property (@(posedge clk) disable iff (rst)
        fwd_case |-> (((merged ^ arr_word) & ~last_mask) == '0));

    p_no_fwd_on_miss_r5: assert property (@(posedge clk) disable iff (rst)
        (rd_en && !fwd_case) |-> (merged == arr_word));

    p_valid_tracks_issue_r8: assert property (@(posedge clk) disable iff (rst)
        rd_valid == vsh[VL-1]);

endmodule

bind lane_mask_ram lmr_chk #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .RD_LAT(RD_LAT), .VLD_LEAD(VLD_LEAD)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .wr_be    (wr_be),
    .rd_en    (rd_en),
    .rd_addr  (rd_addr),
    .rd_valid (rd_valid),
    .p_vld    (pend.vld),
    .merged   (rd_merged),
    .arr_word (arr_rdata)
);

// File: tb/sim_lane_mask_ram.sv
`timescale 1ns/1ps
module sim_lane_mask_ram;

    localparam int DW    = 32;
    localparam int AW    = 6;
    localparam int NL    = DW / 8;
    localparam int LAT   = 2;
    localparam int LEAD  = 1;
    localparam int DL    = LAT - 1;
    localparam int VD    = LAT - 1 - LEAD;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [DW-1:0] wr_data = '0;
    logic [NL-1:0] wr_be = '0;
    logic          rd_en = 1'b0;
    logic [AW-1:0] rd_addr = '0;
    logic [DW-1:0] rd_data;
    logic          rd_valid;

    always #2 clk = ~clk;

    lane_mask_ram #(.DATA_W(DW), .ADDR_W(AW), .RD_LAT(LAT), .VLD_LEAD(LEAD), .INIT_ZERO(1'b1)) u0 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .wr_be(wr_be), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .rd_valid(rd_valid)
    );

    int            n_tests = 0;
    int            n_fail  = 0;
    int            edge_n  = 0;
    bit            done    = 1'b0;
    bit            hist_rd  [8];
    logic [DW-1:0] hist_exp [8];
    string         hist_tag [8];
    logic [DW-1:0] refm [DEPTH];

    function automatic logic [DW-1:0] pat(input int a, input int k);
        return (DW'(a) * 32'h0103_0507) ^ (DW'(k) * 32'h9E37_79B9) ^ 32'h5A00_00A5;
    endfunction

    task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic step(input bit we, input int wa, input logic [DW-1:0] wd,
                        input logic [NL-1:0] wbe, input bit re, input int ra, input string tag);
        int idx;
        wr_en   = we;
        wr_addr = AW'(wa);
        wr_data = wd;
        wr_be   = wbe;
        rd_en   = re;
        rd_addr = AW'(ra);
        @(posedge clk);
        edge_n++;
        idx = edge_n % 8;
        hist_rd[idx] = re;
        if (re) begin
            hist_exp[idx] = refm[ra];   // reads see writes from earlier edges only
            hist_tag[idx] = tag;
        end
        if (we) begin
            for (int l = 0; l < NL; l++) begin
                if (wbe[l]) refm[wa][l*8 +: 8] = wd[l*8 +: 8];
            end
        end
        @(negedge clk);
        if (edge_n >= VD) begin
            check("R8 rd_valid", DW'(rd_valid), DW'(hist_rd[(edge_n - VD) % 8]));
        end
        if (edge_n >= DL && hist_rd[(edge_n - DL) % 8]) begin
            check(hist_tag[(edge_n - DL) % 8], rd_data, hist_exp[(edge_n - DL) % 8]);
        end
    endtask

    task automatic idle();
        step(1'b0, 0, '0, '0, 1'b0, 0, "");
    endtask

    task automatic summary();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    endtask

    initial begin
        for (int i = 0; i < 8; i++) hist_rd[i] = 1'b0;
        for (int i = 0; i < DEPTH; i++) refm[i] = '0;
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 rd_valid during reset", DW'(rd_valid), '0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 rd_valid after reset", DW'(rd_valid), '0);

        // R1: cleared contents, back-to-back reads
        for (int a = 0; a < DEPTH; a++) step(1'b0, 0, '0, '0, 1'b1, a, "R1 zero after reset");
        idle();

        // R2: full-word writes everywhere, then read back
        for (int a = 0; a < DEPTH; a++) step(1'b1, a, pat(a, 1), '1, 1'b0, 0, "");
        for (int a = 0; a < DEPTH; a++) step(1'b0, 0, '0, '0, 1'b1, a, "R2 full write readback");
        idle();

        // R3: every lane mask, read after commit
        for (int m = 0; m < 16; m++) begin
            step(1'b1, m, ~pat(m, 7), NL'(m), 1'b0, 0, "");
            idle();
            step(1'b0, 0, '0, '0, 1'b1, m, "R3 masked lanes kept");
        end

        // R4: every lane mask, read on the very next edge
        for (int m = 0; m < 16; m++) begin
            step(1'b1, 16 + m, pat(m, 11), NL'(m), 1'b0, 0, "");
            step(1'b0, 0, '0, '0, 1'b1, 16 + m, "R4 forward merge");
        end
        idle();

        // R5: read and write to distinct addresses on one edge
        for (int a = 0; a < 32; a++) begin
            step(1'b1, a, pat(a, 23), NL'(a % 16) | 4'h1, 1'b1, DEPTH - 1 - a, "R5 independent ports");
        end
        idle();

        // R6: same address on one edge returns the old word
        for (int m = 1; m < 16; m += 2) begin
            step(1'b1, 40 + m, pat(m, 31), NL'(m), 1'b1, 40 + m, "R6 same-edge read old");
            step(1'b0, 0, '0, '0, 1'b1, 40 + m, "R4 forward after same-edge");
        end
        idle();

        // R9: two chained writes then an immediate read
        for (int k = 0; k < 6; k++) begin
            step(1'b1, 50 + k, pat(k, 41), 4'h3 | NL'(k % 4), 1'b0, 0, "");
            step(1'b1, 50 + k, pat(k, 43), 4'hC | NL'(k % 3), 1'b0, 0, "");
            step(1'b0, 0, '0, '0, 1'b1, 50 + k, "R9 chained writes");
        end
        idle();

        // R7: continuous reads mixed with writes
        for (int i = 0; i < 24; i++) begin
            step((i % 3) == 0, (i * 5) % DEPTH, pat(i, 53), NL'(i % 16),
                 1'b1, (i * 7) % DEPTH, "R7 latency back-to-back");
        end
        repeat (LAT + 2) idle();

        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            summary();
            $finish;
        end
    end

endmodule